// File: doc/BRIEF.md
# Fault Latch and Reaction Manager

This block gathers raw fault detections from a motor-driver power stage and turns them into sticky status bits that software reads: a one-byte summary, four per-switch overcurrent bits and two per-output open-load bits. It also drives an active-low fault pin and an output-disable signal that forces the power stage off when a fault needs it.

Faults are grouped into four reaction classes: overcurrent, over-temperature, supply voltage (overvoltage and undervoltage together) and active-state open load. Each class has its own retry-select input. With retry off, the output-disable stays asserted until software issues a clear. With retry on, the output-disable drops by itself once the raw condition has been absent for `RETRY_LIMIT` consecutive clock edges, while the status bit stays set for software to see. A communication error and a power-on reset are reported only and never disable the outputs. A single-cycle clear strobe wipes all status and all held reactions.

Top module: `fault_reaction_mgr`

## Requirements
- R1: After reset the summary reads 8'h60: POR (bit 6) is 1 and FAULT (bit 5) is 1. Every other status bit and `drv_disable` are 0. Summary bit order from bit 7 down is: communication error, POR, FAULT, overvoltage, undervoltage, overcurrent, over-temperature, open load.
- R2: FAULT (summary bit 5) is 1 exactly when any other summary bit is 1. `fault_n` is the inverse of FAULT.
- R3: A raw fault seen at a rising edge sets its status bit after that edge. The bit stays set until a clear, whatever the raw input does afterwards.
- R4: `oc_status` bit 3 is high-side OUT1, bit 2 is low-side OUT1, bit 1 is high-side OUT2 and bit 0 is low-side OUT2. Each bit latches its own switch's raw input. Summary bit 2 is set when any switch overcurrents.
- R5: While `ov_sel` equals 2'b11, a raw overvoltage is ignored. It sets no status bit and does not disable the outputs.
- R6: A raw open load on an output counts only when `ol_en` and `active_state` are both 1. `ol_status` bit 1 is OUT1 and bit 0 is OUT2. Summary bit 0 is set when either output reports open load.
- R7: `clr_flt` held for one cycle clears all status bits, POR included, and all held reactions. A fault detected at the same edge as the clear is latched anyway.
- R8: With a class's retry input at 0, a fault in that class sets `drv_disable`. It stays set until a clear.
- R9: With a class's retry input at 1, `drv_disable` falls after `RETRY_LIMIT` consecutive edges at which that class saw no fault. The class's status bit stays set.
- R10: `retry_vm` selects the reaction for undervoltage as well as for overvoltage.
- R11: A communication error or a raw power-on reset sets its status bit but never sets `drv_disable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_comm_err | input | 1 | Communication error pulse |
| raw_por | input | 1 | Power-on reset detection |
| raw_ov | input | 1 | Supply overvoltage detection |
| raw_uv | input | 1 | Supply undervoltage detection |
| raw_oc | input | 4 | Per-switch overcurrent, order as in R4 |
| raw_ot | input | 1 | Over-temperature detection |
| raw_ol | input | 2 | Per-output open load, bit 1 OUT1 |
| active_state | input | 1 | Power stage is in its active state |
| ol_en | input | 1 | Open-load detection enable |
| ov_sel | input | 2 | Overvoltage threshold select, 2'b11 masks |
| retry_oc | input | 1 | Retry reaction for overcurrent |
| retry_ot | input | 1 | Retry reaction for over-temperature |
| retry_vm | input | 1 | Retry reaction for over- and undervoltage |
| retry_ol | input | 1 | Retry reaction for open load |
| clr_flt | input | 1 | One-cycle clear-all strobe |
| summary | output | 8 | Summary status byte |
| oc_status | output | 4 | Per-switch overcurrent status |
| ol_status | output | 2 | Per-output open-load status |
| fault_n | output | 1 | Active-low fault pin |
| drv_disable | output | 1 | Forces the power stage off |

## Verification
The bench builds the block with `RETRY_LIMIT` set to 4. That keeps the retry countdown only a few cycles long, so the bench can step through the exact edge at which `drv_disable` falls. It can also cover many retry restarts, where a fault arrives again mid-countdown, within a short random phase. Directed sequences cover the masked overvoltage, the gated open load, the undervoltage-under-overvoltage-retry case and a clear that coincides with a new fault.

// File: rtl/fault_mgr_pkg.sv
package fault_mgr_pkg;

    localparam int NUM_CLASS = 4;
    localparam int CLS_OC    = 0;
    localparam int CLS_OT    = 1;
    localparam int CLS_VM    = 2;
    localparam int CLS_OL    = 3;

    localparam int NUM_SW    = 4;
    localparam int NUM_OUT   = 2;

    localparam int SUM_COMM  = 7;
    localparam int SUM_POR   = 6;
    localparam int SUM_ANY   = 5;
    localparam int SUM_OV    = 4;
    localparam int SUM_UV    = 3;
    localparam int SUM_OC    = 2;
    localparam int SUM_OT    = 1;
    localparam int SUM_OL    = 0;

    typedef struct packed {
        logic                 comm;
        logic                 por;
        logic                 ov;
        logic                 uv;
        logic                 ot;
        logic [NUM_SW-1:0]    sw_oc;
        logic [NUM_OUT-1:0]   out_ol;
    } fault_vec_t;

endpackage

// File: rtl/fault_qualify.sv
module fault_qualify
    import fault_mgr_pkg::*;
(
    input  logic                  raw_comm_err,
    input  logic                  raw_por,
    input  logic                  raw_ov,
    input  logic                  raw_uv,
    input  logic [NUM_SW-1:0]     raw_oc,
    input  logic                  raw_ot,
    input  logic [NUM_OUT-1:0]    raw_ol,
    input  logic                  active_state,
    input  logic                  ol_en,
    input  logic [1:0]            ov_sel,
    output fault_vec_t            det,
    output logic [NUM_CLASS-1:0]  cls_det
);

    localparam logic [1:0] OV_MASKED = 2'b11;

    logic ov_armed;
    logic ol_armed;

    always_comb begin
        ov_armed = (ov_sel != OV_MASKED);
        ol_armed = ol_en & active_state;

        det.comm   = raw_comm_err;
        det.por    = raw_por;
        det.ov     = raw_ov & ov_armed;
        det.uv     = raw_uv;
        det.ot     = raw_ot;
        det.sw_oc  = raw_oc;
        det.out_ol = raw_ol & {NUM_OUT{ol_armed}};

        cls_det         = '0;
        cls_det[CLS_OC] = |det.sw_oc;
        cls_det[CLS_OT] = det.ot;
        cls_det[CLS_VM] = det.ov | det.uv;
        cls_det[CLS_OL] = |det.out_ol;
    end

endmodule

// File: rtl/fault_status_latch.sv
module fault_status_latch
    import fault_mgr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fault_vec_t det,
    input  logic       clr,
    output fault_vec_t status
);

    localparam fault_vec_t RESET_VAL = '{comm: 1'b0, por: 1'b1, ov: 1'b0,
                                         uv: 1'b0, ot: 1'b0, sw_oc: '0,
                                         out_ol: '0};

    fault_vec_t st_d;
    fault_vec_t st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end
        st_d = st_d | det;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q;

endmodule

// File: rtl/fault_retry_timer.sv
module fault_retry_timer #(
    parameter int RETRY_LIMIT = 1000,
    parameter int CNT_W       = (RETRY_LIMIT > 1) ? $clog2(RETRY_LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det,
    input  logic retry,
    input  logic clr,
    output logic hold
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(RETRY_LIMIT - 1);

    typedef struct packed {
        logic             hold;
        logic [CNT_W-1:0] quiet;
    } timer_t;

    timer_t tm_d;
    timer_t tm_q;

    always_comb begin
        tm_d = tm_q;
        if (det) begin
            tm_d.hold  = 1'b1;
            tm_d.quiet = '0;
        end else if (clr) begin
            tm_d.hold  = 1'b0;
            tm_d.quiet = '0;
        end else if (tm_q.hold && retry) begin
            if (tm_q.quiet == LAST) begin
                tm_d.hold  = 1'b0;
                tm_d.quiet = '0;
            end else begin
                tm_d.quiet = tm_q.quiet + 1'b1;
            end
        end else begin
            tm_d.quiet = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign hold = tm_q.hold;

endmodule

// File: rtl/fault_reaction_mgr.sv
module fault_reaction_mgr
    import fault_mgr_pkg::*;
#(
    parameter int RETRY_LIMIT = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                raw_comm_err,
    input  logic                raw_por,
    input  logic                raw_ov,
    input  logic                raw_uv,
    input  logic [NUM_SW-1:0]   raw_oc,
    input  logic                raw_ot,
    input  logic [NUM_OUT-1:0]  raw_ol,
    input  logic                active_state,
    input  logic                ol_en,
    input  logic [1:0]          ov_sel,
    input  logic                retry_oc,
    input  logic                retry_ot,
    input  logic                retry_vm,
    input  logic                retry_ol,
    input  logic                clr_flt,
    output logic [7:0]          summary,
    output logic [NUM_SW-1:0]   oc_status,
    output logic [NUM_OUT-1:0]  ol_status,
    output logic                fault_n,
    output logic                drv_disable
);

    fault_vec_t           det;
    fault_vec_t           status;
    logic [NUM_CLASS-1:0] cls_det;
    logic [NUM_CLASS-1:0] cls_retry;
    logic [NUM_CLASS-1:0] cls_hold;
    logic                 any_fault;

    fault_qualify u_qualify (
        .raw_comm_err (raw_comm_err),
        .raw_por      (raw_por),
        .raw_ov       (raw_ov),
        .raw_uv       (raw_uv),
        .raw_oc       (raw_oc),
        .raw_ot       (raw_ot),
        .raw_ol       (raw_ol),
        .active_state (active_state),
        .ol_en        (ol_en),
        .ov_sel       (ov_sel),
        .det          (det),
        .cls_det      (cls_det)
    );

    fault_status_latch u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .det    (det),
        .clr    (clr_flt),
        .status (status)
    );

    always_comb begin
        cls_retry         = '0;
        cls_retry[CLS_OC] = retry_oc;
        cls_retry[CLS_OT] = retry_ot;
        cls_retry[CLS_VM] = retry_vm;
        cls_retry[CLS_OL] = retry_ol;
    end

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
        fault_retry_timer #(
            .RETRY_LIMIT (RETRY_LIMIT)
        ) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .det   (cls_det[c]),
            .retry (cls_retry[c]),
            .clr   (clr_flt),
            .hold  (cls_hold[c])
        );
    end

    always_comb begin
        any_fault = status.comm | status.por | status.ov | status.uv |
                    status.ot | (|status.sw_oc) | (|status.out_ol);

        summary           = '0;
        summary[SUM_COMM] = status.comm;
        summary[SUM_POR]  = status.por;
        summary[SUM_ANY]  = any_fault;
        summary[SUM_OV]   = status.ov;
        summary[SUM_UV]   = status.uv;
        summary[SUM_OC]   = |status.sw_oc;
        summary[SUM_OT]   = status.ot;
        summary[SUM_OL]   = |status.out_ol;

        oc_status   = status.sw_oc;
        ol_status   = status.out_ol;
        fault_n     = ~any_fault;
        drv_disable = |cls_hold;
    end

endmodule

// File: rtl/fault_mgr_checker.sv
module fault_mgr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       raw_comm_err,
    input logic       raw_por,
    input logic       raw_ov,
    input logic       raw_uv,
    input logic [3:0] raw_oc,
    input logic       raw_ot,
    input logic [1:0] raw_ol,
    input logic       active_state,
    input logic       ol_en,
    input logic [1:0] ov_sel,
    input logic       retry_oc,
    input logic       retry_ot,
    input logic       retry_vm,
    input logic       retry_ol,
    input logic       clr_flt,
    input logic [7:0] summary,
    input logic [3:0] oc_status,
    input logic [1:0] ol_status,
    input logic       fault_n,
    input logic       drv_disable
);

    logic quiet_raw;
    assign quiet_raw = !raw_comm_err && !raw_por && !raw_ov && !raw_uv &&
                       (raw_oc == 4'b0) && !raw_ot && (raw_ol == 2'b0);

    AST_OT_SETS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        raw_ot |=> (summary[1] && summary[5] && !fault_n)); // R2

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (summary[1] && !clr_flt) |=> summary[1]); // R3

    AST_OC_SWITCH_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        raw_oc[3] |=> (oc_status[3] && summary[2])); // R4

    AST_OV_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_sel == 2'b11 && !summary[4]) |=> !summary[4]); // R5

    AST_OL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ol_en || !active_state) && ol_status == 2'b00 && !summary[0])
        |=> (ol_status == 2'b00)); // R6

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flt && quiet_raw) |=> (summary == 8'h00 && fault_n && !drv_disable)); // R7

    AST_LATCHED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_disable && !clr_flt && !retry_oc && !retry_ot && !retry_vm && !retry_ol)
        |=> drv_disable); // R8

    AST_REPORT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_disable && !raw_ov && !raw_uv && raw_oc == 4'b0 && !raw_ot && raw_ol == 2'b0)
        |=> !drv_disable); // R11

endmodule

bind fault_reaction_mgr fault_mgr_checker i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .raw_comm_err (raw_comm_err),
    .raw_por      (raw_por),
    .raw_ov       (raw_ov),
    .raw_uv       (raw_uv),
    .raw_oc       (raw_oc),
    .raw_ot       (raw_ot),
    .raw_ol       (raw_ol),
    .active_state (active_state),
    .ol_en        (ol_en),
    .ov_sel       (ov_sel),
    .retry_oc     (retry_oc),
    .retry_ot     (retry_ot),
    .retry_vm     (retry_vm),
    .retry_ol     (retry_ol),
    .clr_flt      (clr_flt),
    .summary      (summary),
    .oc_status    (oc_status),
    .ol_status    (ol_status),
    .fault_n      (fault_n),
    .drv_disable  (drv_disable)
);

// File: tb/test_fault_reaction_mgr.sv
`timescale 1ns/1ps
module test_fault_reaction_mgr;

    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raw_comm_err = 0, raw_por = 0, raw_ov = 0, raw_uv = 0, raw_ot = 0;
    logic [3:0] raw_oc = 0;
    logic [1:0] raw_ol = 0;
    logic active_state = 0, ol_en = 0;
    logic [1:0] ov_sel = 0;
    logic retry_oc = 0, retry_ot = 0, retry_vm = 0, retry_ol = 0;
    logic clr_flt = 0;
    logic [7:0] summary;
    logic [3:0] oc_status;
    logic [1:0] ol_status;
    logic fault_n, drv_disable;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    fault_reaction_mgr #(.RETRY_LIMIT(N)) i_fault_reaction_mgr (
        .clk(clk), .rst_n(rst_n), .raw_comm_err(raw_comm_err), .raw_por(raw_por),
        .raw_ov(raw_ov), .raw_uv(raw_uv), .raw_oc(raw_oc), .raw_ot(raw_ot),
        .raw_ol(raw_ol), .active_state(active_state), .ol_en(ol_en), .ov_sel(ov_sel),
        .retry_oc(retry_oc), .retry_ot(retry_ot), .retry_vm(retry_vm),
        .retry_ol(retry_ol), .clr_flt(clr_flt), .summary(summary),
        .oc_status(oc_status), .ol_status(ol_status), .fault_n(fault_n),
        .drv_disable(drv_disable)
    );

    // behavioural reference model
    bit m_comm, m_por, m_ov, m_uv, m_ot;
    bit [3:0] m_oc;
    bit [1:0] m_ol;
    bit m_hold [4];
    int m_quiet [4];

    function automatic bit [7:0] m_summary();
        bit any;
        any = m_comm | m_por | m_ov | m_uv | m_ot | (m_oc != 0) | (m_ol != 0);
        return {m_comm, m_por, any, m_ov, m_uv, (m_oc != 0), m_ot, (m_ol != 0)};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_comm = 0; m_por = 1; m_ov = 0; m_uv = 0; m_ot = 0; m_oc = 0; m_ol = 0;
            for (int c = 0; c < 4; c++) begin m_hold[c] = 0; m_quiet[c] = 0; end
        end else begin
            bit ovd;
            bit [1:0] old;
            bit cd [4];
            bit rt [4];
            ovd = raw_ov && (ov_sel != 2'b11);
            old = (ol_en && active_state) ? raw_ol : 2'b00;
            if (clr_flt) begin
                m_comm = 0; m_por = 0; m_ov = 0; m_uv = 0; m_ot = 0; m_oc = 0; m_ol = 0;
            end
            if (raw_comm_err) m_comm = 1;
            if (raw_por) m_por = 1;
            if (ovd) m_ov = 1;
            if (raw_uv) m_uv = 1;
            if (raw_ot) m_ot = 1;
            m_oc = m_oc | raw_oc;
            m_ol = m_ol | old;
            cd[0] = (raw_oc != 0); cd[1] = raw_ot; cd[2] = ovd || raw_uv; cd[3] = (old != 0);
            rt[0] = retry_oc; rt[1] = retry_ot; rt[2] = retry_vm; rt[3] = retry_ol;
            for (int c = 0; c < 4; c++) begin
                if (cd[c]) begin
                    m_hold[c] = 1; m_quiet[c] = 0;
                end else if (clr_flt) begin
                    m_hold[c] = 0; m_quiet[c] = 0;
                end else if (m_hold[c] && rt[c]) begin
                    m_quiet[c]++;
                    if (m_quiet[c] == N) begin m_hold[c] = 0; m_quiet[c] = 0; end
                end else begin
                    m_quiet[c] = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 summary vs model", summary, m_summary());
            chk("R4 oc_status vs model", oc_status, m_oc);
            chk("R6 ol_status vs model", ol_status, m_ol);
            chk("R2 fault_n vs model", fault_n, !m_summary()[5]);
            chk("R8 drv_disable vs model", drv_disable,
                m_hold[0] | m_hold[1] | m_hold[2] | m_hold[3]);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear();
        clr_flt = 1; cyc(1); clr_flt = 0;
    endtask

    initial begin
        #20000000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        chk("R1 reset summary", summary, 8'h60);
        chk("R1 reset drv_disable", drv_disable, 0);
        chk("R2 reset fault_n", fault_n, 0);

        clear();
        chk("R7 clear wipes POR", summary, 8'h00);
        chk("R2 fault_n released", fault_n, 1);

        raw_ot = 1; cyc(1); raw_ot = 0;
        chk("R3 ot latched", summary, 8'h22);
        chk("R8 latched disable", drv_disable, 1);
        cyc(10);
        chk("R3 ot sticky", summary, 8'h22);
        chk("R8 latched disable holds", drv_disable, 1);
        clear();
        chk("R7 clear releases disable", drv_disable, 0);

        ov_sel = 2'b11; raw_ov = 1; cyc(1); raw_ov = 0;
        chk("R5 masked ov status", summary, 8'h00);
        chk("R5 masked ov disable", drv_disable, 0);
        ov_sel = 2'b00; raw_ov = 1; cyc(1); raw_ov = 0;
        chk("R5 unmasked ov", summary, 8'h30);
        clear();

        retry_vm = 1; raw_uv = 1; cyc(1); raw_uv = 0;
        chk("R10 uv disables", drv_disable, 1);
        cyc(N - 1);
        chk("R9 retry still held", drv_disable, 1);
        cyc(1);
        chk("R9 retry released", drv_disable, 0);
        chk("R9 status kept", summary, 8'h28);
        retry_vm = 0;
        clear();

        raw_oc = 4'b0100; cyc(1); raw_oc = 0;
        chk("R4 low-side OUT1", oc_status, 4'b0100);
        chk("R4 summary oc", summary, 8'h24);
        clear();

        raw_ol = 2'b10; ol_en = 0; active_state = 1; cyc(1);
        ol_en = 1; active_state = 0; cyc(1);
        raw_ol = 0;
        chk("R6 gated ol", ol_status, 2'b00);
        ol_en = 1; active_state = 1; raw_ol = 2'b01; cyc(1); raw_ol = 0;
        chk("R6 OUT2 ol", ol_status, 2'b01);
        chk("R6 summary ol", summary, 8'h21);
        clear();

        raw_comm_err = 1; raw_por = 1; cyc(1); raw_comm_err = 0; raw_por = 0;
        chk("R11 report only status", summary, 8'he0);
        chk("R11 no disable", drv_disable, 0);

        clr_flt = 1; raw_ot = 1; cyc(1); clr_flt = 0; raw_ot = 0;
        chk("R7 detect wins over clear", summary, 8'h22);
        clear();

        for (int i = 0; i < 400; i++) begin
            raw_comm_err = ($urandom_range(0, 19) == 0);
            raw_por      = ($urandom_range(0, 39) == 0);
            raw_ov       = ($urandom_range(0, 9) == 0);
            raw_uv       = ($urandom_range(0, 14) == 0);
            raw_ot       = ($urandom_range(0, 14) == 0);
            raw_oc       = ($urandom_range(0, 9) == 0) ? 4'($urandom) : 4'b0;
            raw_ol       = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b0;
            active_state = 1'($urandom);
            ol_en        = 1'($urandom);
            ov_sel       = 2'($urandom);
            retry_oc     = ($urandom_range(0, 3) != 0);
            retry_ot     = ($urandom_range(0, 3) != 0);
            retry_vm     = ($urandom_range(0, 3) != 0);
            retry_ol     = ($urandom_range(0, 3) != 0);
            clr_flt      = ($urandom_range(0, 24) == 0);
            cyc(1);
        end
        clr_flt = 0;
        cyc(2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule